// File: doc/BRIEF.md
# Reset and Vector-Fetch Sequencer

This block decides when a 16-bit-bus processor core is really reset and then boots it. It watches an active-low reset pin and an active-low halt pin, both resynchronised to the core clock. The reset pin is shared: the core can also pull it low for a fixed time when a software reset instruction runs. A low pin from outside normally resets the core at once. While the core's own pulse is under way, a low pin only counts as a reset once it has lasted long enough: either reset alone for 132 clocks, or reset and halt together for 10 clocks.

After a qualified reset ends, the sequencer waits a fixed start-up time. It then reads four 16-bit words from low memory with a request/acknowledge handshake. The first two words become the 32-bit supervisor stack pointer and the last two become the 32-bit program counter, high word first in each case. When the fourth word has been captured, the interrupt mask is set to all ones and a one-cycle start pulse tells the instruction fetch logic that it may begin at the loaded program counter.

Top module: `cpu_boot_seq`

## Requirements
- R1: While `rst_n` is low, `core_rst_o` is 1, `rst_drive_n_o` is 1, `rd_req_o` and `fetch_go_o` are 0, and `ssp_o`, `pc_o` and `ipl_o` are 0.
- R2: Outside a self-driven pulse, a low `rst_pin_n_i` resets the core. `core_rst_o` stays 1, with no read request and no start pulse, for as long as the synchronised pin stays low.
- R3: After `core_rst_o` falls, `rd_req_o` stays low for exactly 4 clocks. The sequencer then reads the byte addresses 0x000000, 0x000002, 0x000004 and 0x000006, in that order. Each address and the request are held until `rd_ack_i` is sampled high.
- R4: `ssp_o` = {word@0x0, word@0x2} and `pc_o` = {word@0x4, word@0x6}, with the upper 16 bits taken from the first word read.
- R5: In the clock after the fourth word is captured, `ipl_o` becomes 3'b111 and `fetch_go_o` is high for exactly one clock per boot.
- R6: A high `sw_rst_req_i` sampled while the core is running and no pulse is active drives `rst_drive_n_o` low for exactly 124 clocks. This pulse does not reset the core: `ssp_o` and `pc_o` are unchanged and no boot follows. A request made during a pulse, or while the core is not running, is ignored.
- R7: While the self-driven pulse is guarding the pin, a low reset pin run of 131 sampled clocks does not reset the core, and a run of 132 does.
- R8: While guarded, reset and halt low together for 9 sampled clocks do not reset the core, and 10 clocks do.
- R9: A reset during the vector reads abandons them, and the next boot starts again at address 0x000000.
- R10: Both pins pass through two synchronising flops. If the reset pin is first low at rising edge k, `core_rst_o` is 0 after edge k+1 and 1 after edge k+2. Counting from the bench's drive point just after an edge, this is the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| rst_pin_n_i | input | 1 | Level of the shared active-low reset pin |
| halt_pin_n_i | input | 1 | Level of the active-low halt pin |
| sw_rst_req_i | input | 1 | Software reset instruction request |
| rst_drive_n_o | output | 1 | Active-low drive onto the reset pin |
| rd_req_o | output | 1 | Vector word read request |
| rd_addr_o | output | 24 | Byte address of the requested word |
| rd_ack_i | input | 1 | Read acknowledge; data valid when high |
| rd_data_i | input | 16 | Read data word |
| ssp_o | output | 32 | Supervisor stack pointer |
| pc_o | output | 32 | Program counter |
| ipl_o | output | 3 | Interrupt priority mask |
| core_rst_o | output | 1 | Core held in reset |
| fetch_go_o | output | 1 | One-cycle start of the first instruction fetch |

## Verification
The hardest situation to reach is the guarded window, where an outside reset overlaps the block's own pulse and must last exactly 131 or 132 clocks, or overlap halt for 9 or 10 clocks. The bench models the shared pin as the AND of the block's drive and an outside driver. It starts the outside driver on the falling clock edge right after the drive goes low, so the length of the low run on the pin is known to the clock. Boots are swept over several data seeds and acknowledge delays. One further reset is injected in the middle of the vector reads.

// File: rtl/cbs_pkg.sv
// Package: shared state encoding for the reset and vector-fetch sequencer.
// Assumes: four vector words; the order of the states is the read order.
package cbs_pkg;
    typedef enum logic [2:0] {
        ST_RESET  = 3'd0,
        ST_START  = 3'd1,
        ST_SSP_HI = 3'd2,
        ST_SSP_LO = 3'd3,
        ST_PC_HI  = 3'd4,
        ST_PC_LO  = 3'd5,
        ST_RUN    = 3'd6
    } boot_state_t;
endpackage

// File: rtl/cbs_sync.sv
// Module: multi-flop synchroniser for asynchronous pin levels.
// Assumes: inputs are level signals; reset value is all ones (pins idle high).
module cbs_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    // Shift the pin levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/cbs_rst_qual.sv
// Module: reset qualifier and software reset pulse generator.
// Generates the self-driven reset pulse. While that pulse is guarding the
// shared pin, a low pin only counts as a core reset after LONG_HOLD clocks
// alone, or BOTH_HOLD clocks together with halt.
// Assumes: pin_low/halt_low are already synchronised; run_i is high only
// when the core is executing.
module cbs_rst_qual #(
    parameter int unsigned PULSE_CLKS = 124,
    parameter int unsigned LONG_HOLD  = 132,
    parameter int unsigned BOTH_HOLD  = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_low,
    input  logic halt_low,
    input  logic run_i,
    input  logic sw_req_i,
    output logic drive_n_o,
    output logic hit_o
);
    localparam int unsigned PW = $clog2(PULSE_CLKS + 1);
    localparam int unsigned LW = $clog2(LONG_HOLD + 1);
    localparam int unsigned BW = $clog2(BOTH_HOLD + 1);

    logic [PW-1:0] pulse_cnt;
    logic [LW-1:0] low_cnt;
    logic [BW-1:0] both_cnt;
    logic          guard_q;
    logic          accept;
    logic          both_low;
    logic          long_hit;
    logic          both_hit;

    assign accept   = sw_req_i && run_i && (pulse_cnt == '0) && !guard_q;
    assign both_low = pin_low && halt_low;
    assign long_hit = pin_low && (low_cnt == LW'(LONG_HOLD - 1));
    assign both_hit = both_low && (both_cnt == BW'(BOTH_HOLD - 1));
    assign hit_o    = pin_low && (!guard_q || long_hit || both_hit);

    // Count down the self-driven pulse length.
    always_ff @(posedge clk) begin
        if (!rst_n)                pulse_cnt <= '0;
        else if (accept)           pulse_cnt <= PW'(PULSE_CLKS);
        else if (pulse_cnt != '0)  pulse_cnt <= pulse_cnt - 1'b1;
    end

    // Guard the pin from pulse start until the pulse has ended and the pin reads high.
    always_ff @(posedge clk) begin
        if (!rst_n)                                guard_q <= 1'b0;
        else if (accept)                           guard_q <= 1'b1;
        else if ((pulse_cnt == '0) && !pin_low)    guard_q <= 1'b0;
    end

    // Measure the consecutive low run of the reset pin (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n || !pin_low)                 low_cnt <= '0;
        else if (low_cnt != LW'(LONG_HOLD))     low_cnt <= low_cnt + 1'b1;
    end

    // Measure the consecutive run of reset and halt both low (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n || !both_low)                both_cnt <= '0;
        else if (both_cnt != BW'(BOTH_HOLD))    both_cnt <= both_cnt + 1'b1;
    end

    assign drive_n_o = (pulse_cnt == '0);
endmodule

// File: rtl/cbs_vec_fetch.sv
// Module: boot state machine that reads the stack pointer and program
// counter vectors, sets the interrupt mask and starts instruction fetch.
// Assumes: hit_i restarts the boot from any state; vector words are
// word-aligned at byte address 0, 2, 4, 6 and read high word first.
module cbs_vec_fetch
    import cbs_pkg::*;
#(
    parameter int unsigned ADDR_W       = 24,
    parameter int unsigned DATA_W       = 16,
    parameter int unsigned IPL_W        = 3,
    parameter int unsigned STARTUP_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_i,
    input  logic              pin_low_i,
    input  logic              rd_ack_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic [2*DATA_W-1:0] ssp_o,
    output logic [2*DATA_W-1:0] pc_o,
    output logic [IPL_W-1:0]  ipl_o,
    output logic              core_rst_o,
    output logic              fetch_go_o,
    output logic              run_o
);
    localparam int unsigned SW = $clog2(STARTUP_CLKS + 1);

    boot_state_t           state;
    logic [SW-1:0]         start_cnt;
    logic [2*DATA_W-1:0]   ssp_q;
    logic [2*DATA_W-1:0]   pc_q;
    logic [IPL_W-1:0]      ipl_q;
    logic                  go_q;
    logic [1:0]            word_idx;

    // Select the vector word index from the read state.
    always_comb begin
        case (state)
            ST_SSP_LO: word_idx = 2'd1;
            ST_PC_HI:  word_idx = 2'd2;
            ST_PC_LO:  word_idx = 2'd3;
            default:   word_idx = 2'd0;
        endcase
    end

    // Sequence reset, start-up delay, four word reads and run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_RESET;
            start_cnt <= '0;
            ssp_q     <= '0;
            pc_q      <= '0;
            ipl_q     <= '0;
            go_q      <= 1'b0;
        end else begin
            go_q <= 1'b0;
            if (hit_i) begin
                state     <= ST_RESET;
                start_cnt <= '0;
            end else begin
                case (state)
                    ST_RESET: begin
                        start_cnt <= '0;
                        if (!pin_low_i) state <= ST_START;
                    end
                    ST_START: begin
                        if (start_cnt == SW'(STARTUP_CLKS - 1)) state <= ST_SSP_HI;
                        else start_cnt <= start_cnt + 1'b1;
                    end
                    ST_SSP_HI: if (rd_ack_i) begin
                        ssp_q[2*DATA_W-1:DATA_W] <= rd_data_i;
                        state <= ST_SSP_LO;
                    end
                    ST_SSP_LO: if (rd_ack_i) begin
                        ssp_q[DATA_W-1:0] <= rd_data_i;
                        state <= ST_PC_HI;
                    end
                    ST_PC_HI: if (rd_ack_i) begin
                        pc_q[2*DATA_W-1:DATA_W] <= rd_data_i;
                        state <= ST_PC_LO;
                    end
                    ST_PC_LO: if (rd_ack_i) begin
                        pc_q[DATA_W-1:0] <= rd_data_i;
                        ipl_q <= '1;
                        go_q  <= 1'b1;
                        state <= ST_RUN;
                    end
                    ST_RUN: ;
                    default: state <= ST_RESET;
                endcase
            end
        end
    end

    assign rd_req_o   = (state == ST_SSP_HI) || (state == ST_SSP_LO) ||
                        (state == ST_PC_HI)  || (state == ST_PC_LO);
    assign rd_addr_o  = {{(ADDR_W-3){1'b0}}, word_idx, 1'b0};
    assign ssp_o      = ssp_q;
    assign pc_o       = pc_q;
    assign ipl_o      = ipl_q;
    assign core_rst_o = (state == ST_RESET);
    assign fetch_go_o = go_q;
    assign run_o      = (state == ST_RUN);
endmodule

// File: rtl/cpu_boot_seq.sv
// Module: top of the reset and vector-fetch sequencer.
// Synchronises the reset and halt pins, qualifies core resets against the
// self-driven pulse, and boots the core from the low-memory vectors.
// Assumes: rst_pin_n_i is the wired level of the shared pin, which includes
// this block's own rst_drive_n_o.
module cpu_boot_seq #(
    parameter int unsigned ADDR_W       = 24,
    parameter int unsigned DATA_W       = 16,
    parameter int unsigned IPL_W        = 3,
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned STARTUP_CLKS = 4,
    parameter int unsigned PULSE_CLKS   = 124,
    parameter int unsigned LONG_HOLD    = 132,
    parameter int unsigned BOTH_HOLD    = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rst_pin_n_i,
    input  logic                halt_pin_n_i,
    input  logic                sw_rst_req_i,
    output logic                rst_drive_n_o,
    output logic                rd_req_o,
    output logic [ADDR_W-1:0]   rd_addr_o,
    input  logic                rd_ack_i,
    input  logic [DATA_W-1:0]   rd_data_i,
    output logic [2*DATA_W-1:0] ssp_o,
    output logic [2*DATA_W-1:0] pc_o,
    output logic [IPL_W-1:0]    ipl_o,
    output logic                core_rst_o,
    output logic                fetch_go_o
);
    logic [1:0] pins_sync;
    logic       pin_low;
    logic       halt_low;
    logic       hit;
    logic       run;

    cbs_sync #(.W(2), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({halt_pin_n_i, rst_pin_n_i}),
        .q     (pins_sync)
    );

    assign pin_low  = !pins_sync[0];
    assign halt_low = !pins_sync[1];

    cbs_rst_qual #(
        .PULSE_CLKS (PULSE_CLKS),
        .LONG_HOLD  (LONG_HOLD),
        .BOTH_HOLD  (BOTH_HOLD)
    ) qual_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_low   (pin_low),
        .halt_low  (halt_low),
        .run_i     (run),
        .sw_req_i  (sw_rst_req_i),
        .drive_n_o (rst_drive_n_o),
        .hit_o     (hit)
    );

    cbs_vec_fetch #(
        .ADDR_W       (ADDR_W),
        .DATA_W       (DATA_W),
        .IPL_W        (IPL_W),
        .STARTUP_CLKS (STARTUP_CLKS)
    ) fetch_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_i      (hit),
        .pin_low_i  (pin_low),
        .rd_ack_i   (rd_ack_i),
        .rd_data_i  (rd_data_i),
        .rd_req_o   (rd_req_o),
        .rd_addr_o  (rd_addr_o),
        .ssp_o      (ssp_o),
        .pc_o       (pc_o),
        .ipl_o      (ipl_o),
        .core_rst_o (core_rst_o),
        .fetch_go_o (fetch_go_o),
        .run_o      (run)
    );
endmodule

// File: rtl/cpu_boot_seq_chk.sv
// Module: assertion checker for cpu_boot_seq, bound to every instance.
// Assumes: default parameters of the sequencer (24-bit address, 3-bit mask).
module cpu_boot_seq_chk #(
    parameter int unsigned PULSE_CLKS   = 124,
    parameter int unsigned STARTUP_CLKS = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        rst_drive_n_o,
    input logic        rd_req_o,
    input logic [23:0] rd_addr_o,
    input logic        rd_ack_i,
    input logic [2:0]  ipl_o,
    input logic        core_rst_o,
    input logic        fetch_go_o
);
    logic [7:0] drv_run;
    logic [3:0] since_rel;

    // Count consecutive clocks of self-driven reset (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n || rst_drive_n_o) drv_run <= '0;
        else if (drv_run != 8'hff)   drv_run <= drv_run + 1'b1;
    end

    // Count clocks since the core left reset (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n || core_rst_o)    since_rel <= '0;
        else if (since_rel != 4'hf)  since_rel <= since_rel + 1'b1;
    end

    AST_PULSE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        drv_run <= 8'(PULSE_CLKS)); // R6
    AST_PULSE_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_drive_n_o) |-> drv_run == 8'(PULSE_CLKS)); // R6
    AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_o |-> !rd_req_o && !fetch_go_o); // R2
    AST_STARTUP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_req_o) |-> since_rel == 4'(STARTUP_CLKS) && rd_addr_o == 24'h0); // R3
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && !rd_ack_i |=> core_rst_o || (rd_req_o && $stable(rd_addr_o))); // R3
    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> rd_addr_o[0] == 1'b0 && rd_addr_o <= 24'h6); // R3
    AST_GO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_go_o |-> ipl_o == 3'b111 && !rd_req_o); // R5
    AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_go_o |=> !fetch_go_o); // R5
endmodule

bind cpu_boot_seq cpu_boot_seq_chk chk_i (.*);

// File: tb/cpu_boot_seq_tb_top.sv
module cpu_boot_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ext_drv_n;
    logic        halt_pin_n;
    logic        sw_req;
    logic        rst_pin_n;
    logic        rst_drive_n;
    logic        rd_req;
    logic [23:0] rd_addr;
    logic        rd_ack;
    logic [15:0] rd_data;
    logic [31:0] ssp;
    logic [31:0] pc;
    logic [2:0]  ipl;
    logic        core_rst;
    logic        fetch_go;

    int errors = 0;
    int checks = 0;
    int mem_seed = 0;
    int mem_wait = 0;
    int go_cnt = 0;
    bit rst_seen = 0;
    bit gap_run = 0;
    int gap_cnt = 0;
    int gap_last = -1;
    int nlog = 0;
    logic [23:0] alog [8];

    always #5 clk = ~clk;

    // Shared pin: wired low by either the block or the outside driver.
    assign rst_pin_n = rst_drive_n & ext_drv_n;

    cpu_boot_seq dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .rst_pin_n_i   (rst_pin_n),
        .halt_pin_n_i  (halt_pin_n),
        .sw_rst_req_i  (sw_req),
        .rst_drive_n_o (rst_drive_n),
        .rd_req_o      (rd_req),
        .rd_addr_o     (rd_addr),
        .rd_ack_i      (rd_ack),
        .rd_data_i     (rd_data),
        .ssp_o         (ssp),
        .pc_o          (pc),
        .ipl_o         (ipl),
        .core_rst_o    (core_rst),
        .fetch_go_o    (fetch_go)
    );

    function automatic logic [15:0] mem_word(input int seed, input logic [23:0] a);
        return 16'((seed + 1) * 931 + 32'(a) * 4369 + 5);
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Memory responder: acknowledge after mem_wait clocks, one clock wide.
    initial begin
        int wcnt = 0;
        rd_ack = 1'b0;
        rd_data = '0;
        forever begin
            @(negedge clk);
            if (!rd_req || rd_ack) begin
                rd_ack = 1'b0;
                wcnt = 0;
            end else if (wcnt >= mem_wait) begin
                rd_ack = 1'b1;
                rd_data = mem_word(mem_seed, rd_addr);
            end else begin
                wcnt++;
            end
        end
    end

    // Monitor: reset seen, start-up gap, read address order, start pulses.
    initial begin
        logic        prev_req = 1'b0;
        logic [23:0] prev_addr = '0;
        forever begin
            @(negedge clk);
            if (core_rst === 1'b1) begin
                rst_seen = 1;
                nlog = 0;
                gap_run = 1;
                gap_cnt = 0;
            end else if (gap_run) begin
                if (rd_req) begin
                    gap_run = 0;
                    gap_last = gap_cnt;
                end else begin
                    gap_cnt++;
                end
            end
            if (rd_req === 1'b1 && (!prev_req || rd_addr != prev_addr)) begin
                if (nlog < 8) alog[nlog] = rd_addr;
                nlog++;
            end
            prev_req = rd_req;
            prev_addr = rd_addr;
            if (fetch_go === 1'b1) go_cnt++;
        end
    end

    task automatic wait_go();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (fetch_go) return;
        end
        chk("R5", "start pulse timeout", 0, 1);
    endtask

    task automatic check_boot(input int seed);
        chk("R4", "ssp", ssp, {mem_word(seed, 24'h0), mem_word(seed, 24'h2)});
        chk("R4", "pc", pc, {mem_word(seed, 24'h4), mem_word(seed, 24'h6)});
        chk("R5", "ipl", ipl, 3'b111);
        chk("R3", "startup gap", gap_last, 4);
        chk("R3", "word reads", nlog, 4);
        for (int i = 0; i < 4; i++) chk("R3", "read address order", alog[i], i * 2);
    endtask

    task automatic ext_reset(input int len);
        @(negedge clk);
        ext_drv_n = 1'b0;
        repeat (len) @(negedge clk);
        chk("R2", "core held during pin low", core_rst, 1);
        chk("R2", "no read during reset", rd_req, 0);
        ext_drv_n = 1'b1;
    endtask

    // Software pulse with an optional overlapping outside reset or halt.
    task automatic pulse_case(input int low_len, input int halt_len, input bit expect_rst,
                              input string req);
        logic [31:0] ssp0 = ssp;
        logic [31:0] pc0 = pc;
        int go0 = go_cnt;
        rst_seen = 0;
        @(negedge clk);
        sw_req = 1'b1;
        @(negedge clk);
        sw_req = 1'b0;
        chk("R6", "drive low after request", rst_drive_n, 0);
        if (low_len > 0) begin
            ext_drv_n = 1'b0;
            repeat (low_len) @(negedge clk);
            ext_drv_n = 1'b1;
        end
        if (halt_len > 0) begin
            repeat (20) @(negedge clk);
            halt_pin_n = 1'b0;
            repeat (halt_len) @(negedge clk);
            halt_pin_n = 1'b1;
        end
        repeat (320) @(negedge clk);
        chk(req, "core reset taken", rst_seen, expect_rst);
        if (expect_rst) begin
            chk(req, "one boot after reset", go_cnt - go0, 1);
            check_boot(mem_seed);
        end else begin
            chk(req, "ssp kept", ssp, ssp0);
            chk(req, "pc kept", pc, pc0);
            chk(req, "no boot", go_cnt - go0, 0);
        end
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int len;
        int go0;
        rst_n = 1'b0;
        ext_drv_n = 1'b1;
        halt_pin_n = 1'b1;
        sw_req = 1'b0;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1", "core_rst", core_rst, 1);
        chk("R1", "drive", rst_drive_n, 1);
        chk("R1", "rd_req", rd_req, 0);
        chk("R1", "fetch_go", fetch_go, 0);
        chk("R1", "ssp", ssp, 0);
        chk("R1", "pc", pc, 0);
        chk("R1", "ipl", ipl, 0);
        rst_n = 1'b1;
        wait_go();
        check_boot(0);

        // Boot sweep over data seeds and acknowledge delays (R2 R3 R4 R5)
        for (int s = 1; s <= 8; s++) begin
            mem_seed = s;
            mem_wait = s % 4;
            go0 = go_cnt;
            ext_reset(4 + s);
            wait_go();
            repeat (3) @(negedge clk);
            chk("R5", "single start pulse", go_cnt - go0, 1);
            check_boot(s);
        end

        // R10 synchroniser latency
        @(negedge clk);
        ext_drv_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk("R10", "core_rst after two edges", core_rst, 0);
        @(negedge clk);
        chk("R10", "core_rst after three edges", core_rst, 1);
        repeat (3) @(negedge clk);
        ext_drv_n = 1'b1;
        wait_go();
        check_boot(mem_seed);

        // R6 pulse length and no core reset
        len = 0;
        rst_seen = 0;
        go0 = go_cnt;
        @(negedge clk);
        sw_req = 1'b1;
        @(negedge clk);
        sw_req = 1'b0;
        while (!rst_drive_n && len < 400) begin
            len++;
            if (len == 50) sw_req = 1'b1;
            if (len == 51) sw_req = 1'b0;
            @(negedge clk);
        end
        chk("R6", "pulse length with repeat request", len, 124);
        repeat (10) @(negedge clk);
        chk("R6", "no core reset from pulse", rst_seen, 0);
        chk("R6", "no boot from pulse", go_cnt - go0, 0);
        chk("R6", "pin idle after pulse", rst_drive_n, 1);

        // R6 request ignored while core is in reset
        @(negedge clk);
        ext_drv_n = 1'b0;
        repeat (6) @(negedge clk);
        sw_req = 1'b1;
        @(negedge clk);
        sw_req = 1'b0;
        len = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (!rst_drive_n) len++;
        end
        chk("R6", "request ignored in reset", len, 0);
        ext_drv_n = 1'b1;
        wait_go();

        // R7 long hold boundary, R8 reset+halt boundary
        mem_seed = 11;
        mem_wait = 1;
        pulse_case(131, 0, 0, "R7");
        pulse_case(132, 0, 1, "R7");
        mem_seed = 12;
        pulse_case(0, 9, 0, "R8");
        pulse_case(0, 10, 1, "R8");

        // R9 reset in the middle of the vector reads
        mem_seed = 13;
        mem_wait = 3;
        @(negedge clk);
        ext_drv_n = 1'b0;
        repeat (4) @(negedge clk);
        ext_drv_n = 1'b1;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (rd_req && rd_addr == 24'h4) break;
        end
        chk("R9", "reached third word", rd_addr, 24'h4);
        mem_seed = 14;
        ext_drv_n = 1'b0;
        repeat (4) @(negedge clk);
        ext_drv_n = 1'b1;
        wait_go();
        check_boot(14);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule